// File: doc/BRIEF.md
# DMA Interrupt Coalescing Controller

This block decides when a scatter-gather DMA engine should interrupt its host. It receives a one-cycle pulse for every finished descriptor, a one-cycle pulse whenever a transfer begins, and a tick from a slow timebase. Two programmable values shape its behaviour. The first is a completion threshold: that many completions must build up before the completion status bit is set. The second is an 8-bit idle count: once a transfer starts or a descriptor completes, this many timebase ticks must pass with no further activity before the idle status bit is set. The idle count catches any completions left over when the threshold is not reached.

Both status bits are sticky and are cleared by write-1-to-clear strobes. A single interrupt line combines the two status bits, each masked by its own enable. The threshold and idle count sit in registers inside the block and are loaded by write strobes. The register bus decoding that produces those strobes lives outside the block.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset the threshold is 1, the idle count is 0, and both status bits and `irq_o` are 0. One completion after reset therefore sets the completion status.
- R2: With threshold N, the completion status is set in the cycle after the Nth completion pulse. The count then starts again from N.
- R3: While fewer than N completions have built up, the completion status stays 0, however long the block is idle.
- R4: A threshold write restarts the completion count at the new value, and a written value of 0 acts as 1. A completion pulse in the same cycle as a threshold write is discarded.
- R5: While the idle count register holds 0, the idle status is never set.
- R6: With idle interrupts enabled and idle count D in the range 1 to 255, the idle status is set in the cycle after the Dth tick that follows the most recent start or completion.
- R7: A start or completion pulse reloads the idle countdown to D. This holds even when the pulse lands on the same cycle as the tick that would have expired it, and no idle status results from that tick.
- R8: A completion that sets the completion status cancels any running idle countdown.
- R9: When the idle enable is 0 as the countdown reaches zero, the idle status is not set.
- R10: Each status bit stays set until its clear strobe is asserted. A set and a clear in the same cycle leave the bit set.
- R11: `irq_o` is 1 exactly when (completion status AND completion enable) OR (idle status AND idle enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_done_i | input | 1 | One-cycle pulse per finished descriptor |
| xfer_start_i | input | 1 | One-cycle pulse when a transfer begins |
| tick_i | input | 1 | Timebase tick for the idle countdown |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_wdata_i | input | THR_W | Threshold value to write (0 acts as 1) |
| dly_we_i | input | 1 | Idle count write strobe |
| dly_wdata_i | input | DLY_W | Idle count value to write |
| cmp_ie_i | input | 1 | Completion interrupt enable |
| dly_ie_i | input | 1 | Idle interrupt enable (also gates the setting of the idle status) |
| clr_cmp_i | input | 1 | Write-1-to-clear strobe for the completion status |
| clr_dly_i | input | 1 | Write-1-to-clear strobe for the idle status |
| cmp_stat_o | output | 1 | Sticky completion status |
| dly_stat_o | output | 1 | Sticky idle status |
| irq_o | output | 1 | Combined, masked interrupt |

## Verification
Three kinds of event can fall on the same clock edge. The tick that would expire the idle countdown can coincide with a start or completion pulse that reloads it. The completion that reaches the threshold can coincide with a running countdown, which it must cancel. A status set can coincide with its clear strobe. Directed sequences place the expiring tick and a start pulse on the same edge, and place a threshold-reaching completion two ticks into a countdown. The test then watches both status bits for many ticks afterwards. A long random run with dense pulse rates produces these collisions again and again, and every cycle is judged against a bench model built from the requirements.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    localparam int NUM_SRC = 2;
    localparam int IDX_CMP = 0;
    localparam int IDX_DLY = 1;

    typedef struct packed {
        logic done;
        logic start;
        logic tick;
    } evt_t;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    function automatic logic rearm_evt(input evt_t e);
        return e.done | e.start;
    endfunction

endpackage

// File: rtl/coal_counter.sv
module coal_counter #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_i,
    input  logic             thr_we_i,
    input  logic [THR_W-1:0] thr_wdata_i,
    output logic             hit_o
);
    localparam logic [THR_W-1:0] ONE = THR_W'(1);

    logic [THR_W-1:0] thr_q;
    logic [THR_W-1:0] cnt_q;
    logic [THR_W-1:0] thr_eff;

    assign thr_eff = (thr_wdata_i == '0) ? ONE : thr_wdata_i;
    assign hit_o   = done_i && !thr_we_i && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= ONE;
            cnt_q <= ONE;
        end else if (thr_we_i) begin
            thr_q <= thr_eff;
            cnt_q <= thr_eff;
        end else if (done_i) begin
            cnt_q <= (cnt_q == ONE) ? thr_q : cnt_q - ONE;
        end
    end

    // R4: the remaining count never reaches zero
    p_cnt_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q != '0);

    // R2: the count restarts from the threshold once it is reached
    p_cnt_reload_r2: assert property (@(posedge clk) disable iff (rst)
        (done_i && !thr_we_i && cnt_q == ONE) |=> (cnt_q == $past(thr_q)));

endmodule

// File: rtl/idle_timer.sv
module idle_timer
    import irq_coal_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt_i,
    input  logic             cancel_i,
    input  logic             en_i,
    input  logic             dly_we_i,
    input  logic [DLY_W-1:0] dly_wdata_i,
    output logic             expire_o,
    output logic             active_o
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] tmr_q;
    logic             active_q;
    logic             rearm;
    logic             last_tick;

    assign rearm     = rearm_evt(evt_i);
    assign last_tick = evt_i.tick && active_q && (tmr_q == ONE);
    assign expire_o  = last_tick && !rearm && !cancel_i && en_i && (dly_q != '0);
    assign active_o  = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q    <= '0;
            tmr_q    <= '0;
            active_q <= 1'b0;
        end else begin
            if (dly_we_i) begin
                dly_q <= dly_wdata_i;
            end
            if (cancel_i) begin
                active_q <= 1'b0;
            end else if (rearm) begin
                tmr_q    <= dly_q;
                active_q <= (dly_q != '0);
            end else if (evt_i.tick && active_q) begin
                if (tmr_q == ONE) begin
                    active_q <= 1'b0;
                end else begin
                    tmr_q <= tmr_q - ONE;
                end
            end
        end
    end

    // R5: a running countdown never holds a zero count
    p_active_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (tmr_q != '0));

    // R6: an expiry ends the countdown
    p_expire_stops_r6: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !active_q);

endmodule

// File: rtl/irq_status.sv
module irq_status
    import irq_coal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    input  src_vec_t en_i,
    output src_vec_t stat_o,
    output logic     irq_o
);
    src_vec_t stat_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                stat_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                stat_q[i] <= 1'b0;
            end
        end

        // R10: a set bit holds until its clear strobe
        p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
            (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & en_i);

endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import irq_coal_pkg::*;
#(
    parameter int THR_W = 8,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             desc_done_i,
    input  logic             xfer_start_i,
    input  logic             tick_i,
    input  logic             thr_we_i,
    input  logic [THR_W-1:0] thr_wdata_i,
    input  logic             dly_we_i,
    input  logic [DLY_W-1:0] dly_wdata_i,
    input  logic             cmp_ie_i,
    input  logic             dly_ie_i,
    input  logic             clr_cmp_i,
    input  logic             clr_dly_i,
    output logic             cmp_stat_o,
    output logic             dly_stat_o,
    output logic             irq_o
);
    evt_t     evt;
    logic     cmp_hit;
    logic     dly_expire;
    logic     tmr_active;
    src_vec_t set_v;
    src_vec_t clr_v;
    src_vec_t en_v;
    src_vec_t stat_v;

    assign evt.done  = desc_done_i;
    assign evt.start = xfer_start_i;
    assign evt.tick  = tick_i;

    coal_counter #(.THR_W(THR_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .done_i     (desc_done_i),
        .thr_we_i   (thr_we_i),
        .thr_wdata_i(thr_wdata_i),
        .hit_o      (cmp_hit)
    );

    idle_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .cancel_i   (cmp_hit),
        .en_i       (dly_ie_i),
        .dly_we_i   (dly_we_i),
        .dly_wdata_i(dly_wdata_i),
        .expire_o   (dly_expire),
        .active_o   (tmr_active)
    );

    always_comb begin
        set_v = '0;
        clr_v = '0;
        en_v  = '0;
        set_v[IDX_CMP] = cmp_hit;
        set_v[IDX_DLY] = dly_expire;
        clr_v[IDX_CMP] = clr_cmp_i;
        clr_v[IDX_DLY] = clr_dly_i;
        en_v[IDX_CMP]  = cmp_ie_i;
        en_v[IDX_DLY]  = dly_ie_i;
    end

    irq_status u_stat (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v),
        .clr_i (clr_v),
        .en_i  (en_v),
        .stat_o(stat_v),
        .irq_o (irq_o)
    );

    assign cmp_stat_o = stat_v[IDX_CMP];
    assign dly_stat_o = stat_v[IDX_DLY];

    // R8: reaching the threshold leaves no idle countdown running
    p_cancel_r8: assert property (@(posedge clk) disable iff (rst)
        cmp_hit |=> !tmr_active);

    // R11: no status set means no interrupt
    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!cmp_stat_o && !dly_stat_o) |-> !irq_o);

    // R9: the idle status cannot rise while idle interrupts are disabled
    p_no_idle_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!dly_ie_i && !dly_stat_o) |=> !dly_stat_o);

endmodule

// File: tb/tb_irq_coalesce_ctrl.sv
module tb_irq_coalesce_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       done = 0, start = 0, tick = 0;
    logic       thr_we = 0, dly_we = 0;
    logic [7:0] thr_wd = 0, dly_wd = 0;
    logic       cmp_ie = 0, dly_ie = 0, clr_c = 0, clr_d = 0;
    logic       cmp_stat, dly_stat, irq;

    int checks = 0;
    int fails  = 0;

    // bench reference state
    logic [7:0] m_thr, m_cnt, m_dly, m_tmr;
    logic       m_act, m_cs, m_ds;

    always #4 clk = ~clk;

    irq_coalesce_ctrl dut (
        .clk(clk), .rst(rst), .desc_done_i(done), .xfer_start_i(start), .tick_i(tick),
        .thr_we_i(thr_we), .thr_wdata_i(thr_wd), .dly_we_i(dly_we), .dly_wdata_i(dly_wd),
        .cmp_ie_i(cmp_ie), .dly_ie_i(dly_ie), .clr_cmp_i(clr_c), .clr_dly_i(clr_d),
        .cmp_stat_o(cmp_stat), .dly_stat_o(dly_stat), .irq_o(irq)
    );

    function automatic logic exp_irq(input logic cs, input logic ds, input logic ce, input logic de);
        return (cs & ce) | (ds & de);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_thr = 8'd1; m_cnt = 8'd1; m_dly = 8'd0; m_tmr = 8'd0;
            m_act = 1'b0; m_cs = 1'b0; m_ds = 1'b0;
        end else begin
            logic hit, exp;
            hit = done && !thr_we && (m_cnt == 8'd1);
            exp = tick && m_act && (m_tmr == 8'd1) && !(done || start) && dly_ie && (m_dly != 8'd0);
            if (thr_we) begin
                m_thr = (thr_wd == 8'd0) ? 8'd1 : thr_wd;
                m_cnt = m_thr;
            end else if (done) begin
                m_cnt = (m_cnt == 8'd1) ? m_thr : m_cnt - 8'd1;
            end
            if (hit) m_act = 1'b0;
            else if (done || start) begin m_tmr = m_dly; m_act = (m_dly != 8'd0); end
            else if (tick && m_act) begin
                if (m_tmr == 8'd1) m_act = 1'b0; else m_tmr = m_tmr - 8'd1;
            end
            if (dly_we) m_dly = dly_wd;
            if (hit) m_cs = 1'b1; else if (clr_c) m_cs = 1'b0;
            if (exp) m_ds = 1'b1; else if (clr_d) m_ds = 1'b0;
        end
    end

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_model();
        expect_bit(cmp_stat, m_cs, "R2 model cmp_stat");
        expect_bit(dly_stat, m_ds, "R6 model dly_stat");
        expect_bit(irq, exp_irq(m_cs, m_ds, cmp_ie, dly_ie), "R11 model irq");
    endtask

    task automatic step(input logic d, input logic s, input logic t, input logic cc, input logic cd);
        done = d; start = s; tick = t; clr_c = cc; clr_d = cd;
        @(posedge clk);
        #1;
        done = 0; start = 0; tick = 0; clr_c = 0; clr_d = 0; thr_we = 0; dly_we = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        expect_bit(cmp_stat, 0, "R1 reset cmp_stat");
        expect_bit(dly_stat, 0, "R1 reset dly_stat");
        expect_bit(irq, 0, "R1 reset irq");
        step(1, 0, 0, 0, 0);
        expect_bit(cmp_stat, 1, "R1 default threshold one");
        // R10 clear, and set beats clear
        step(0, 0, 0, 1, 0);
        expect_bit(cmp_stat, 0, "R10 w1c clears");
        step(1, 0, 0, 1, 0);
        expect_bit(cmp_stat, 1, "R10 set wins over clear");
        step(0, 0, 0, 0, 0);
        expect_bit(cmp_stat, 1, "R10 sticky");
        // R2/R3 threshold 3
        thr_we = 1; thr_wd = 8'd3; step(0, 0, 0, 1, 0);
        step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        ticks(20);
        expect_bit(cmp_stat, 0, "R3 short of threshold");
        step(1, 0, 0, 0, 0);
        expect_bit(cmp_stat, 1, "R2 third completion");
        step(0, 0, 0, 1, 0);
        step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        expect_bit(cmp_stat, 0, "R2 count restarted");
        step(1, 0, 0, 0, 0);
        expect_bit(cmp_stat, 1, "R2 second batch");
        // R4 zero threshold, and write colliding with completion
        thr_we = 1; thr_wd = 8'd0; step(0, 0, 0, 1, 0);
        step(1, 0, 0, 0, 0);
        expect_bit(cmp_stat, 1, "R4 zero acts as one");
        step(0, 0, 0, 1, 0);
        thr_we = 1; thr_wd = 8'd2; step(1, 0, 0, 0, 0);
        expect_bit(cmp_stat, 0, "R4 completion with write dropped");
        step(1, 0, 0, 0, 0);
        expect_bit(cmp_stat, 0, "R4 first after write");
        step(1, 0, 0, 0, 0);
        expect_bit(cmp_stat, 1, "R4 second after write");
        step(0, 0, 0, 1, 0);
        // R5 idle count zero
        dly_ie = 1;
        step(0, 1, 0, 0, 0);
        ticks(300);
        expect_bit(dly_stat, 0, "R5 zero idle count");
        // R6 idle count 4
        dly_we = 1; dly_wd = 8'd4; step(0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        ticks(3);
        expect_bit(dly_stat, 0, "R6 before fourth tick");
        ticks(1);
        expect_bit(dly_stat, 1, "R6 fourth tick");
        expect_bit(irq, 1, "R11 idle enabled");
        dly_ie = 0; #1;
        expect_bit(irq, 0, "R11 idle masked");
        dly_ie = 1;
        // R7 reload on last tick
        step(0, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0);
        ticks(3);
        step(0, 1, 1, 0, 0);
        expect_bit(dly_stat, 0, "R7 start on expiring tick");
        ticks(3);
        expect_bit(dly_stat, 0, "R7 reloaded count");
        ticks(1);
        expect_bit(dly_stat, 1, "R7 fires after reload");
        // R9 enable off
        step(0, 0, 0, 0, 1);
        dly_ie = 0;
        step(0, 1, 0, 0, 0);
        ticks(10);
        expect_bit(dly_stat, 0, "R9 disabled idle");
        dly_ie = 1;
        // R8 cancel by completion interrupt (threshold 2)
        step(1, 0, 0, 0, 0);
        ticks(2);
        step(1, 0, 0, 0, 0);
        expect_bit(cmp_stat, 1, "R8 threshold reached");
        ticks(10);
        expect_bit(dly_stat, 0, "R8 countdown cancelled");
        cmp_ie = 1; #1;
        expect_bit(irq, 1, "R11 completion enabled");
        // random phase against reference
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 64 == 0) begin thr_we = 1; thr_wd = 8'($urandom % 5); end
            if ($urandom % 64 == 0) begin dly_we = 1; dly_wd = 8'($urandom % 7); end
            if ($urandom % 32 == 0) cmp_ie = ~cmp_ie;
            if ($urandom % 40 == 0) dly_ie = ~dly_ie;
            step(($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 2) == 0,
                 ($urandom % 16) == 0, ($urandom % 16) == 0);
            check_model();
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule